// File: doc/BRIEF.md
# Symbol-Power Timing Tracker

This block holds the receiver's sampling phase near its best point once coarse timing acquisition has finished. It does not estimate a timing error from early and late samples. Instead it watches how strong each received symbol is. Right after acquisition it builds a reference sum of symbol powers. Every few symbols it compares a short running window of the latest powers with that reference. When the recent power has sagged below the reference, the phase has drifted away from its best point. The block then sends a one-cycle adjust request, with a direction bit, to the sampling clock phase shifter.

Each power is divided by the current gain-amplifier setting before it is stored, so a gain step is not taken for a timing drift. The division uses a small table of reciprocals. The block has two symbol sources:
- In spread-spectrum mode it correlates each incoming complex chip against the 11-chip Barker code. The symbol power is the largest squared magnitude found in the middle third of each symbol.
- In complementary-code mode, an external Walsh transform supplies one maximum power per symbol. The reference ratio is derated to 0.9 in this mode.

While the reference is being gathered, the block nudges the phase forward at a fixed steady rate.

Top module: `symtrack_loop`

## Requirements
- R1: After reset, `adj_pulse` and `adj_dir` are 0, and they stay 0 until `acq_done` has been seen.
- R2: In chip mode, the correlation is Σ_j c(10−j)·x_j. Here x_j is the sample received j chips ago (j=0 is the newest) and c(0..10) = +1,−1,+1,+1,−1,+1,+1,+1,−1,−1,−1. The same sum is formed separately for the real and imaginary parts. The instantaneous power is re²+im². The symbol power is the maximum of that power at chip positions 3 to 7 of each 11-chip symbol. Chip positions count 0..10 from `acq_done`.
- R3: Each symbol power P is normalised as floor(P·floor(256/(g+1))/256), where g is `gain_idx`.
- R4: After `acq_done`, the first 32 normalised powers form the reference sum. The current sum always covers the latest 16 normalised powers.
- R5: In tracking, the error is evaluated after every 4th symbol. In chip mode an adjust is requested when 2·current < reference. Otherwise no pulse is produced.
- R6: During reference collection, a pulse with `adj_dir`=1 is produced after every 8th symbol, counting the symbol that ends collection.
- R7: `adj_dir` starts at 1 when tracking begins. A requesting evaluation keeps the previous direction, unless the evaluation just before it also requested, in which case the direction inverts.
- R8: `preamble_end` with `rate_high`=1 switches to Walsh mode and restarts collection. In Walsh mode the reference is 16 symbols, the current window is 8 symbols, and an adjust is requested when 512·current < 230·reference. Only `acq_done` leaves Walsh mode.
- R9: `preamble_end` with `rate_high`=0 changes neither the mode nor the loop state.
- R10: Chip samples are ignored in Walsh mode. Walsh powers are ignored in chip mode. Both are ignored before the first `acq_done`.
- R11: Each `adj_pulse` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_done | input | 1 | Acquisition finished; starts chip-mode reference collection |
| chip_valid | input | 1 | One received chip is present |
| chip_re | input | SAMP_W | Chip real part, signed |
| chip_im | input | SAMP_W | Chip imaginary part, signed |
| walsh_valid | input | 1 | One Walsh-transform symbol power is present |
| walsh_pow | input | 2·SAMP_W+7 | Walsh maximum power for the symbol |
| gain_idx | input | GAIN_W | Gain setting g (gain g+1) |
| preamble_end | input | 1 | Preamble finished |
| rate_high | input | 1 | Payload uses the Walsh-coded rates |
| adj_pulse | output | 1 | Phase adjust request |
| adj_dir | output | 1 | Adjust direction, 1 = advance |

## Verification
The assertions assume the following about the inputs:
- `gain_idx` is stable from a symbol's last chip (or Walsh power) until that power has been normalised, two cycles later.
- `acq_done` and `preamble_end` arrive only when no symbol is still inside the pipeline.
- Chip symbols and Walsh powers never arrive in the same cycle.

The stimulus respects these assumptions. It sends whole symbols and leaves several idle cycles after each one. It changes the gain, and raises the control pulses, only inside those gaps. It also offers chips and Walsh powers in the modes where they must be ignored.

// File: rtl/stl_pkg.sv
package stl_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_REF, ST_TRACK} stl_state_e;
  typedef enum logic {MD_CHIP, MD_WALSH} stl_mode_e;

  localparam int CHIPS = 11;
  // bit b weights the sample received b chips ago; bit 10 is the first code chip
  localparam logic [CHIPS-1:0] BARKER = 11'b10110111000;

endpackage

// File: rtl/stl_chip_power.sv
module stl_chip_power
  import stl_pkg::*;
#(
  parameter int SAMP_W = 8,
  parameter int POW_W  = 2*SAMP_W+7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     chip_v,
  input  logic signed [SAMP_W-1:0] chip_re,
  input  logic signed [SAMP_W-1:0] chip_im,
  output logic                     sym_v,
  output logic [POW_W-1:0]         sym_pow
);
  localparam int CORR_W = SAMP_W + 4;
  localparam int IDX_W  = $clog2(CHIPS);
  localparam int WIN_LO = CHIPS / 3;
  localparam int WIN_HI = (2 * CHIPS) / 3;

  logic signed [SAMP_W-1:0] sr_re [CHIPS];
  logic signed [SAMP_W-1:0] sr_im [CHIPS];
  logic [IDX_W-1:0] idx, idx1;
  logic             v1;
  logic [POW_W-1:0] win_max;

  // delay line: stage 0 takes the new chip, each later stage the one before
  for (genvar k = 0; k < CHIPS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        sr_re[k] <= '0;
        sr_im[k] <= '0;
      end else if (chip_v) begin
        if (k == 0) begin
          sr_re[k] <= chip_re;
          sr_im[k] <= chip_im;
        end else begin
          sr_re[k] <= sr_re[k-1];
          sr_im[k] <= sr_im[k-1];
        end
      end
    end
  end

  logic signed [CORR_W-1:0]   acc_re, acc_im;
  logic signed [2*CORR_W-1:0] sq_re, sq_im;
  logic [POW_W-1:0]           p_now;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int j = 0; j < CHIPS; j++) begin
      if (BARKER[j]) begin
        acc_re = acc_re + CORR_W'(sr_re[j]);
        acc_im = acc_im + CORR_W'(sr_im[j]);
      end else begin
        acc_re = acc_re - CORR_W'(sr_re[j]);
        acc_im = acc_im - CORR_W'(sr_im[j]);
      end
    end
  end

  assign sq_re = acc_re * acc_re;
  assign sq_im = acc_im * acc_im;
  assign p_now = sq_re[POW_W-1:0] + sq_im[POW_W-1:0];

  always_ff @(posedge clk) begin
    sym_v <= 1'b0;
    if (rst || clr) begin
      idx     <= '0;
      idx1    <= '0;
      v1      <= 1'b0;
      win_max <= '0;
      sym_pow <= '0;
    end else begin
      v1   <= chip_v;
      idx1 <= idx;
      if (chip_v) idx <= (idx == IDX_W'(CHIPS-1)) ? '0 : idx + 1'b1;
      if (v1) begin
        if (idx1 >= IDX_W'(WIN_LO) && idx1 <= IDX_W'(WIN_HI) && p_now > win_max)
          win_max <= p_now;
        if (idx1 == IDX_W'(CHIPS-1)) begin
          sym_pow <= win_max;
          sym_v   <= 1'b1;
          win_max <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/stl_gain_norm.sv
module stl_gain_norm #(
  parameter int POW_W  = 23,
  parameter int GAIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_v,
  input  logic [POW_W-1:0]  in_pow,
  input  logic [GAIN_W-1:0] gain_idx,
  output logic              out_v,
  output logic [POW_W-1:0]  out_pow
);
  localparam int NG = 1 << GAIN_W;

  logic [8:0] recip [NG];
  for (genvar g = 0; g < NG; g++) begin : g_lut
    assign recip[g] = 9'(256 / (g + 1));
  end

  logic [POW_W+8:0] prod;
  assign prod = in_pow * recip[gain_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v   <= 1'b0;
      out_pow <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) out_pow <= prod[POW_W+7:8];
    end
  end

  assert_norm_le_R3: assert property (@(posedge clk) disable iff (rst)
    out_v |-> (out_pow <= $past(in_pow)));

endmodule

// File: rtl/stl_window_acc.sv
module stl_window_acc #(
  parameter int POW_W = 23,
  parameter int HIST  = 16,
  parameter int SUM_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [POW_W-1:0] val,
  input  logic [$clog2(HIST):0] cur_len,
  input  logic             ref_en,
  output logic [SUM_W-1:0] cur_sum,
  output logic [SUM_W-1:0] ref_sum
);
  localparam int HA_W = $clog2(HIST);

  logic [POW_W-1:0] hist_mem [HIST];
  logic [HA_W-1:0]  wr;
  logic [HA_W:0]    filled;
  logic [HA_W-1:0]  rd;
  logic [POW_W-1:0] leave;

  assign rd    = wr - cur_len[HA_W-1:0];
  assign leave = (filled >= cur_len) ? hist_mem[rd] : '0;

  always_ff @(posedge clk) begin
    if (push) hist_mem[wr] <= val;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr      <= '0;
      filled  <= '0;
      cur_sum <= '0;
      ref_sum <= '0;
    end else if (push) begin
      wr      <= wr + 1'b1;
      if (filled != (HA_W+1)'(HIST)) filled <= filled + 1'b1;
      cur_sum <= cur_sum + SUM_W'(val) - SUM_W'(leave);
      if (ref_en) ref_sum <= ref_sum + SUM_W'(val);
    end
  end

  assert_ref_frozen_R4: assert property (@(posedge clk) disable iff (rst || clr)
    (!ref_en) |=> $stable(ref_sum));

endmodule

// File: rtl/symtrack_loop.sv
module symtrack_loop
  import stl_pkg::*;
#(
  parameter int SAMP_W       = 8,
  parameter int GAIN_W       = 3,
  parameter int REF_CHIP     = 32,
  parameter int CUR_CHIP     = 16,
  parameter int REF_WALSH    = 16,
  parameter int CUR_WALSH    = 8,
  parameter int EVAL_EVERY   = 4,
  parameter int STEADY_EVERY = 8,
  parameter int DERATE_Q8    = 230
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acq_done,
  input  logic                     chip_valid,
  input  logic signed [SAMP_W-1:0] chip_re,
  input  logic signed [SAMP_W-1:0] chip_im,
  input  logic                     walsh_valid,
  input  logic [2*SAMP_W+6:0]      walsh_pow,
  input  logic [GAIN_W-1:0]        gain_idx,
  input  logic                     preamble_end,
  input  logic                     rate_high,
  output logic                     adj_pulse,
  output logic                     adj_dir
);
  localparam int POW_W = 2*SAMP_W + 7;
  localparam int HIST  = CUR_CHIP;
  localparam int HA_W  = $clog2(HIST);
  localparam int RC_W  = $clog2(REF_CHIP + 1);
  localparam int SUM_W = POW_W + RC_W;
  localparam int CMP_W = SUM_W + RC_W + 9;
  localparam int EV_W  = $clog2(EVAL_EVERY);
  localparam int SD_W  = $clog2(STEADY_EVERY);

  stl_state_e state;
  stl_mode_e  mode;
  logic [RC_W-1:0] ref_cnt;
  logic [EV_W-1:0] trk_cnt;
  logic [SD_W-1:0] sdy_cnt;
  logic dir_q, last_adj, eval_q;

  logic go_walsh, running;
  assign running  = (state != ST_IDLE);
  assign go_walsh = preamble_end && rate_high && running && (mode == MD_CHIP);

  // symbol sources
  logic             chip_sym_v;
  logic [POW_W-1:0] chip_sym_pow;
  stl_chip_power #(.SAMP_W(SAMP_W), .POW_W(POW_W)) u_chip (
    .clk(clk), .rst(rst), .clr(acq_done),
    .chip_v(chip_valid && running && (mode == MD_CHIP)),
    .chip_re(chip_re), .chip_im(chip_im),
    .sym_v(chip_sym_v), .sym_pow(chip_sym_pow)
  );

  logic             raw_v;
  logic [POW_W-1:0] raw_pow;
  logic             walsh_take, chip_take;
  assign walsh_take = walsh_valid && running && (mode == MD_WALSH);
  assign chip_take  = chip_sym_v && (mode == MD_CHIP);
  assign raw_v      = walsh_take || chip_take;
  assign raw_pow    = chip_take ? chip_sym_pow : walsh_pow;

  logic             nv;
  logic [POW_W-1:0] npow;
  stl_gain_norm #(.POW_W(POW_W), .GAIN_W(GAIN_W)) u_norm (
    .clk(clk), .rst(rst), .in_v(raw_v), .in_pow(raw_pow),
    .gain_idx(gain_idx), .out_v(nv), .out_pow(npow)
  );

  logic [HA_W:0]    cur_len;
  logic [RC_W-1:0]  ref_len;
  logic [SUM_W-1:0] cur_sum, ref_sum;
  assign cur_len = (mode == MD_WALSH) ? (HA_W+1)'(CUR_WALSH) : (HA_W+1)'(CUR_CHIP);
  assign ref_len = (mode == MD_WALSH) ? RC_W'(REF_WALSH) : RC_W'(REF_CHIP);

  stl_window_acc #(.POW_W(POW_W), .HIST(HIST), .SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .clr(acq_done || go_walsh),
    .push(nv && running), .val(npow), .cur_len(cur_len),
    .ref_en(state == ST_REF), .cur_sum(cur_sum), .ref_sum(ref_sum)
  );

  // averages compared by cross-multiplying the window lengths
  logic [CMP_W-1:0] lhs, rhs;
  logic             behind, nxt_dir;
  always_comb begin
    lhs = CMP_W'(cur_sum) * CMP_W'(ref_len);
    rhs = CMP_W'(ref_sum) * CMP_W'(cur_len);
    if (mode == MD_WALSH) begin
      lhs = lhs << 8;
      rhs = rhs * CMP_W'(DERATE_Q8);
    end
  end
  assign behind  = (lhs < rhs);
  assign nxt_dir = last_adj ? ~dir_q : dir_q;

  always_ff @(posedge clk) begin
    adj_pulse <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      mode     <= MD_CHIP;
      ref_cnt  <= '0;
      trk_cnt  <= '0;
      sdy_cnt  <= '0;
      dir_q    <= 1'b0;
      last_adj <= 1'b0;
      eval_q   <= 1'b0;
      adj_dir  <= 1'b0;
    end else if (acq_done || go_walsh) begin
      state    <= ST_REF;
      mode     <= acq_done ? MD_CHIP : MD_WALSH;
      ref_cnt  <= '0;
      trk_cnt  <= '0;
      sdy_cnt  <= '0;
      last_adj <= 1'b0;
      eval_q   <= 1'b0;
    end else begin
      eval_q <= 1'b0;
      if (nv && state == ST_REF) begin
        ref_cnt <= ref_cnt + 1'b1;
        if (sdy_cnt == SD_W'(STEADY_EVERY-1)) begin
          sdy_cnt   <= '0;
          adj_pulse <= 1'b1;
          adj_dir   <= 1'b1;
        end else begin
          sdy_cnt <= sdy_cnt + 1'b1;
        end
        if (ref_cnt + 1'b1 == ref_len) begin
          state    <= ST_TRACK;
          trk_cnt  <= '0;
          dir_q    <= 1'b1;
          last_adj <= 1'b0;
        end
      end else if (nv && state == ST_TRACK) begin
        if (trk_cnt == EV_W'(EVAL_EVERY-1)) begin
          trk_cnt <= '0;
          eval_q  <= 1'b1;
        end else begin
          trk_cnt <= trk_cnt + 1'b1;
        end
      end
      if (eval_q) begin
        if (behind) begin
          adj_pulse <= 1'b1;
          adj_dir   <= nxt_dir;
          dir_q     <= nxt_dir;
          last_adj  <= 1'b1;
        end else begin
          last_adj <= 1'b0;
        end
      end
    end
  end

  assert_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
    adj_pulse |=> !adj_pulse);

  assert_idle_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> !adj_pulse);

  assert_steady_fwd_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REF && nv && !acq_done && !go_walsh) |=> (!adj_pulse || adj_dir));

  assert_walsh_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_WALSH && !acq_done) |=> (mode == MD_WALSH));

  assert_low_rate_R9: assert property (@(posedge clk) disable iff (rst)
    (preamble_end && !rate_high && !acq_done) |=> ($stable(mode) && $stable(ref_cnt)));

endmodule

// File: tb/tb_symtrack_loop.sv
module tb_symtrack_loop;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acq_done = 0, chip_valid = 0, walsh_valid = 0, preamble_end = 0, rate_high = 0;
  logic signed [SW-1:0] chip_re = 0, chip_im = 0;
  logic [2*SW+6:0] walsh_pow = 0;
  logic [2:0] gain_idx = 0;
  logic adj_pulse, adj_dir;

  always #(CLK_PERIOD/2) clk = ~clk;

  symtrack_loop dut (
    .clk(clk), .rst(rst), .acq_done(acq_done), .chip_valid(chip_valid),
    .chip_re(chip_re), .chip_im(chip_im), .walsh_valid(walsh_valid),
    .walsh_pow(walsh_pow), .gain_idx(gain_idx), .preamble_end(preamble_end),
    .rate_high(rate_high), .adj_pulse(adj_pulse), .adj_dir(adj_dir)
  );

  int total = 0, bad = 0;
  int code [11] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};

  // bench model of the loop, built from the requirements
  int     m_sr_re [11], m_sr_im [11];
  int     m_idx, m_state, m_mode, m_refc, m_trk, m_dir, m_last, m_n;
  longint m_max;
  longint m_pw [0:1023];
  int     exp_dir [0:1023], exp_tag [0:1023];
  int     exp_n = 0, obs_n = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint norm(input longint p, input int g);
    return (p * (256 / (g + 1))) / 256;
  endfunction

  task automatic m_expect(input int d, input int tag);
    exp_dir[exp_n] = d;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic m_push(input longint np);
    longint cur, refs;
    int cl, rl;
    m_pw[m_n] = np;
    m_n++;
    cl = m_mode ? 8 : 16;
    rl = m_mode ? 16 : 32;
    if (m_state == 1) begin
      m_refc++;
      if (m_refc % 8 == 0) m_expect(1, 6);          // R6
      if (m_refc == rl) begin
        m_state = 2; m_trk = 0; m_dir = 1; m_last = 0;   // R7 start direction
      end
    end else if (m_state == 2) begin
      m_trk++;
      if (m_trk % 4 == 0) begin                      // R5 evaluation spacing
        cur = 0; refs = 0;
        for (int k = m_n - cl; k < m_n; k++) cur += m_pw[k];
        for (int k = 0; k < rl; k++) refs += m_pw[k];
        if (m_mode ? (512 * cur < 230 * refs) : (2 * cur < refs)) begin
          if (m_last) m_dir = 1 - m_dir;             // R7 reversal
          m_expect(m_dir, m_mode ? 8 : 5);
          m_last = 1;
        end else begin
          m_last = 0;
        end
      end
    end
  endtask

  task automatic m_restart(input int md);
    m_state = 1; m_mode = md; m_refc = 0; m_n = 0; m_last = 0;
    if (md == 0) begin
      for (int k = 0; k < 11; k++) begin m_sr_re[k] = 0; m_sr_im[k] = 0; end
      m_idx = 0; m_max = 0;
    end
  endtask

  task automatic m_chip(input int re, input int im);
    longint cr, ci, p;
    if (m_state == 0 || m_mode != 0) return;        // R10
    for (int k = 10; k > 0; k--) begin m_sr_re[k] = m_sr_re[k-1]; m_sr_im[k] = m_sr_im[k-1]; end
    m_sr_re[0] = re; m_sr_im[0] = im;
    cr = 0; ci = 0;
    for (int j = 0; j < 11; j++) begin              // R2 correlation
      cr += code[10-j] * m_sr_re[j];
      ci += code[10-j] * m_sr_im[j];
    end
    p = cr * cr + ci * ci;
    if (m_idx >= 3 && m_idx <= 7 && p > m_max) m_max = p;
    if (m_idx == 10) begin
      m_push(norm(m_max, int'(gain_idx)));           // R3
      m_max = 0;
    end
    m_idx = (m_idx == 10) ? 0 : m_idx + 1;
  endtask

  task automatic send_symbol(input int a_re, input int a_im, input int sh);
    for (int j = 0; j < 11; j++) begin
      @(negedge clk);
      chip_valid = 1;
      chip_re = SW'(a_re * code[(j + sh) % 11]);
      chip_im = SW'(a_im * code[(j + sh) % 11]);
      m_chip(int'(chip_re), int'(chip_im));
    end
    @(negedge clk);
    chip_valid = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_walsh(input longint p);
    @(negedge clk);
    walsh_valid = 1;
    walsh_pow = 23'(p);
    if (m_state != 0 && m_mode == 1) m_push(norm(p, int'(gain_idx)));   // R10 gate
    @(negedge clk);
    walsh_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_acq();
    @(negedge clk); acq_done = 1;
    m_restart(0);
    @(negedge clk); acq_done = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_pre(input bit hi);
    @(negedge clk); preamble_end = 1; rate_high = hi;
    if (hi && m_state != 0 && m_mode == 0) m_restart(1);   // R8 / R9
    @(negedge clk); preamble_end = 0; rate_high = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle_and_count(input string req);
    repeat (10) @(negedge clk);
    check(obs_n == exp_n, req, obs_n, exp_n);
  endtask

  // pulse monitor, away from the active edge
  int prev_pulse = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (adj_pulse) begin
        if (obs_n < exp_n)
          check(adj_dir == exp_dir[obs_n][0],
                exp_tag[obs_n] == 6 ? "R6 steady dir" : (exp_tag[obs_n] == 8 ? "R8 walsh dir" : "R5 R7 chip dir"),
                adj_dir, exp_dir[obs_n]);
        else
          check(1'b0, "R5 unexpected pulse", obs_n, exp_n);
        obs_n++;
      end
      if (prev_pulse == 1 && adj_pulse) check(1'b0, "R11 pulse width", 2, 1);
      prev_pulse = adj_pulse;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R11 actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    m_state = 0; m_mode = 0; m_n = 0;
    repeat (3) @(negedge clk);
    check(adj_pulse == 0, "R1 pulse in reset", adj_pulse, 0);
    @(negedge clk); rst = 0;
    repeat (2) @(negedge clk);
    check(adj_pulse == 0, "R1 pulse after reset", adj_pulse, 0);
    check(adj_dir == 0, "R1 dir after reset", adj_dir, 0);

    // R10: nothing acts before acquisition
    send_symbol(60, 20, 5);
    send_walsh(500000);
    pulse_pre(1);
    settle_and_count("R10 idle inputs");
    check(obs_n == 0, "R10 no pulse before start", obs_n, 0);

    // R4 R6: reference collection with a gain sweep (R3)
    pulse_acq();
    for (int s = 0; s < 32; s++) begin
      gain_idx = 3'(s % 8);
      send_symbol(60 - (s % 5), 20 + (s % 3), 5);
      if (s == 10) send_walsh(400000);        // R10 ignored in chip mode
    end
    settle_and_count("R4 reference phase");
    check(obs_n == 4, "R6 steady pulse count", obs_n, 4);

    // R5: strong symbols keep the error non-negative
    gain_idx = 0;
    base = obs_n;
    for (int s = 0; s < 8; s++) send_symbol(60, 20, 5);
    settle_and_count("R5 strong track");
    check(obs_n == base, "R5 silent when on time", obs_n, base);

    // R5 R7: weakened power, with one misaligned symbol (R2 window)
    gain_idx = 7;
    for (int s = 0; s < 16; s++) send_symbol(60, 20, (s == 5) ? 2 : 5);
    settle_and_count("R7 weak track");
    gain_idx = 0;
    for (int s = 0; s < 8; s++) send_symbol(55, 25, 5);
    gain_idx = 6;
    for (int s = 0; s < 12; s++) send_symbol(50, 10, 5);
    settle_and_count("R2 R3 mixed track");

    // R9: low-rate preamble end keeps chip tracking
    pulse_pre(0);
    base = obs_n;
    gain_idx = 7;
    for (int s = 0; s < 8; s++) send_symbol(40, 10, 5);
    send_walsh(300000);
    settle_and_count("R9 low rate stays");
    check(obs_n > base, "R9 chip evaluations continue", obs_n, base + 1);

    // R8: Walsh mode
    gain_idx = 0;
    pulse_pre(1);
    for (int s = 0; s < 16; s++) send_walsh(100000);
    send_symbol(60, 20, 5);                    // R10 ignored in Walsh mode
    settle_and_count("R8 walsh reference");
    base = obs_n;
    for (int s = 0; s < 8; s++) send_walsh(90000);
    settle_and_count("R8 derate boundary");
    check(obs_n == base, "R8 no pulse at 0.9 edge", obs_n, base);
    for (int s = 0; s < 8; s++) send_walsh(89000);
    settle_and_count("R8 below derate");
    check(obs_n == base + 2, "R8 two pulses below edge", obs_n, base + 2);
    for (int g = 0; g < 8; g++) begin
      gain_idx = 3'(g);
      send_walsh(longint'(60000) * (g + 1));
    end
    gain_idx = 0;
    pulse_pre(1);                              // R8 no effect in Walsh mode
    for (int s = 0; s < 8; s++) send_walsh(120000);
    settle_and_count("R3 walsh gain sweep");

    // restart returns to chip mode
    pulse_acq();
    base = obs_n;
    for (int s = 0; s < 8; s++) send_symbol(45, 30, 5);
    settle_and_count("R4 restart");
    check(obs_n == base + 1, "R6 restart steady", obs_n, base + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule